// File: doc/BRIEF.md
# Operand-Conditioned Eight-Bit ALU

This block is the arithmetic and logic core of a microcoded data path. Two operands, A and B, pass through a conditioning stage before they reach a four-function unit. A can be forced to zero and then complemented. B can be forced to zero. A separate control adds one to a sum. Because the operand controls sit in front of the function unit, subtraction and the all-ones constant come from control settings alone. No extra opcode is needed for either.

The function unit computes AND, NOT B, OR, or a sum with carry-in. A small flag stage reports a zero flag, a negative flag and the carry out of the sum. A build parameter puts one register stage on all outputs so the block can be tested against a clock. That stage is on by default. With the parameter cleared, the block is purely combinational. Shifting, register files and the microsequencer that drives the six controls belong to other blocks.

Top module: `microalu_core`

## Requirements
- R1: `func_sel` picks the function: 2'b00 gives conditioned A AND conditioned B, 2'b01 gives the bitwise complement of conditioned B, 2'b10 gives conditioned A OR conditioned B, and 2'b11 gives conditioned A + conditioned B + `plus_one`, truncated to 8 bits.
- R2: When `a_pass` is 0, the A operand is forced to zero before any inversion.
- R3: When `a_invert` is 1, the function unit receives the bitwise complement of the (possibly zeroed) A operand.
- R4: When `b_pass` is 0, the B operand is forced to zero.
- R5: `plus_one` affects only the sum (code 2'b11). Under the other three codes it has no effect on any output.
- R6: With `a_invert`=1, `plus_one`=1, `a_pass`=`b_pass`=1 and code 2'b11, the result equals B minus A modulo 256.
- R7: With code 2'b01, `b_pass`=0 and `plus_one`=0, the result is 8'hFF whatever the values of A, `a_pass` and `a_invert`.
- R8: With `a_pass`=0, `a_invert`=1 and `b_pass`=0, both code 2'b11 (with `plus_one`=0) and code 2'b10 give 8'hFF.
- R9: `neg` equals result bit 7, and `zero` is 1 exactly when all result bits are 0.
- R10: `carry_out` is the carry out of bit 7 of the sum under code 2'b11. It is 0 under every other code.
- R11: With `REG_OUT`=1, outputs reflect the inputs present at the previous rising clock edge. A clock edge with `rst_n` low sets `result`=0, `zero`=1, `neg`=0 and `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| func_sel | input | 2 | Function code |
| a_pass | input | 1 | 1 passes A, 0 forces A to zero |
| a_invert | input | 1 | 1 complements the conditioned A |
| b_pass | input | 1 | 1 passes B, 0 forces B to zero |
| plus_one | input | 1 | Carry-in of the sum |
| result | output | 8 | Function result |
| zero | output | 1 | Result is all zeros |
| neg | output | 1 | Result bit 7 |
| carry_out | output | 1 | Carry out of the sum |

## Verification
The carry out of the sum and the zero flag can both be set in the same cycle. This happens when a sum wraps to exactly zero, for example 8'h70 + 8'h90, or 8'hFF + 0 with `plus_one` set. It also happens when a subtraction is done with equal operands. The bench drives each of these cases and checks that `carry_out`=1, `zero`=1, `neg`=0 and `result`=0 all appear together on the registered outputs one edge later. A second pair that can coincide is the conditioning of A and the suppression of `plus_one`. Under NOT B, every setting of the A controls is swept with `plus_one` both set and clear, and the result must not move.

// File: rtl/microalu_pkg.sv
// Shared types for the operand-conditioned ALU.
// Assumes a two-bit function code; encodings are fixed by the requirements.
package microalu_pkg;
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_NOTB = 2'b01,
        FN_OR   = 2'b10,
        FN_SUM  = 2'b11
    } func_t;
endpackage

// File: rtl/operand_cond.sv
// Operand conditioning: optional forcing to zero, then optional complement.
// Assumes the gate is applied before inversion; tie inv low for no inversion.
module operand_cond #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         pass,
    input  logic         inv,
    output logic [W-1:0] cond
);
    logic [W-1:0] gated;

    // Zero the operand when not passed, then complement on request.
    always_comb begin
        gated = pass ? raw : '0;
        cond  = inv ? ~gated : gated;
    end
endmodule

// File: rtl/func_unit.sv
// Four-function unit: AND, NOT B, OR and sum with carry-in.
// Assumes operands are already conditioned; carry_in is honoured only by the sum.
module func_unit
    import microalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  func_t        func,
    input  logic         carry_in,
    output logic [W-1:0] res,
    output logic         cy
);
    localparam int SW = W + 1;
    logic [SW-1:0] sum_ext;

    // Widened sum so the carry out of the top bit is visible.
    always_comb sum_ext = SW'(op_a) + SW'(op_b) + SW'(carry_in);

    // Select the function output and qualify the carry by function.
    always_comb begin
        cy = 1'b0;
        unique case (func)
            FN_AND:  res = op_a & op_b;
            FN_NOTB: res = ~op_b;
            FN_OR:   res = op_a | op_b;
            default: begin
                res = sum_ext[W-1:0];
                cy  = sum_ext[W];
            end
        endcase
    end
endmodule

// File: rtl/flag_gen.sv
// Result flags: zero when every bit is clear, negative from the top bit.
// Assumes two's complement interpretation of the result.
module flag_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] res,
    output logic         is_zero,
    output logic         is_neg
);
    localparam int MSB = W - 1;

    // Derive both flags from the result word.
    always_comb begin
        is_zero = (res == '0);
        is_neg  = res[MSB];
    end
endmodule

// File: rtl/microalu_core.sv
// Operand-conditioned ALU top: A/B conditioning, function unit, flags,
// and an optional output register (REG_OUT=1) with synchronous active-low reset.
// Assumes controls are stable for the cycle in which they are sampled.
module microalu_core
    import microalu_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [1:0]   func_sel,
    input  logic         a_pass,
    input  logic         a_invert,
    input  logic         b_pass,
    input  logic         plus_one,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         neg,
    output logic         carry_out
);
    logic [W-1:0] a_c, b_c, res_c;
    logic         cy_c, z_c, n_c;
    func_t        func;

    // Map the raw code onto the function type.
    always_comb func = func_t'(func_sel);

    operand_cond #(.W(W)) u_cond_a (
        .raw (a_in), .pass(a_pass), .inv(a_invert), .cond(a_c)
    );

    operand_cond #(.W(W)) u_cond_b (
        .raw (b_in), .pass(b_pass), .inv(1'b0), .cond(b_c)
    );

    func_unit #(.W(W)) u_fn (
        .op_a(a_c), .op_b(b_c), .func(func), .carry_in(plus_one),
        .res(res_c), .cy(cy_c)
    );

    flag_gen #(.W(W)) u_flags (
        .res(res_c), .is_zero(z_c), .is_neg(n_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Capture the combinational outputs; reset to a zero result.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result    <= '0;
                    zero      <= 1'b1;
                    neg       <= 1'b0;
                    carry_out <= 1'b0;
                end else begin
                    result    <= res_c;
                    zero      <= z_c;
                    neg       <= n_c;
                    carry_out <= cy_c;
                end
            end
        end else begin : g_comb
            // Drive outputs straight from the combinational path.
            always_comb begin
                result    = res_c;
                zero      = z_c;
                neg       = n_c;
                carry_out = cy_c;
            end
        end
    endgenerate
endmodule

// File: rtl/microalu_rules_chk.sv
// Property checker for microalu_core, bound to every instance.
// Assumes the same REG_OUT setting as the bound instance.
module microalu_rules_chk #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [1:0]   func_sel,
    input logic         a_pass,
    input logic         a_invert,
    input logic         b_pass,
    input logic         plus_one,
    input logic [W-1:0] result,
    input logic         zero,
    input logic         neg,
    input logic         carry_out
);
    logic [W-1:0] d_a, d_b;
    logic [1:0]   d_fn;
    logic         d_ap, d_ai, d_bp, d_p1, valid;

    generate
        if (REG_OUT) begin : g_dly
            // Hold the inputs that produced the current registered outputs.
            always_ff @(posedge clk) begin
                d_a <= a_in;  d_b <= b_in;  d_fn <= func_sel;
                d_ap <= a_pass; d_ai <= a_invert; d_bp <= b_pass; d_p1 <= plus_one;
                valid <= rst_n;
            end
        end else begin : g_now
            // Outputs follow inputs directly.
            always_comb begin
                d_a = a_in;  d_b = b_in;  d_fn = func_sel;
                d_ap = a_pass; d_ai = a_invert; d_bp = b_pass; d_p1 = plus_one;
                valid = 1'b1;
            end
        end
    endgenerate

    // R9
    neg_is_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg == result[W-1]);

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

    // R10
    no_carry_outside_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && d_fn != 2'b11) |-> !carry_out);

    // R7
    all_ones_from_notb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && d_fn == 2'b01 && !d_bp) |-> (result == '1));

    // R6
    subtract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && d_fn == 2'b11 && d_ap && d_ai && d_bp && d_p1)
            |-> (result == W'(d_b - d_a)));

    // R2
    a_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && d_fn == 2'b00 && !d_ap && !d_ai) |-> (result == '0));
endmodule

bind microalu_core microalu_rules_chk #(.W(W), .REG_OUT(REG_OUT)) u_rules_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .func_sel(func_sel),
    .a_pass(a_pass), .a_invert(a_invert), .b_pass(b_pass), .plus_one(plus_one),
    .result(result), .zero(zero), .neg(neg), .carry_out(carry_out)
);

// File: tb/tb_microalu_core.sv
module tb_microalu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [1:0] func_sel = '0;
    logic       a_pass = 1'b0, a_invert = 1'b0, b_pass = 1'b0, plus_one = 1'b0;
    logic [7:0] result;
    logic       zero, neg, carry_out;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    microalu_core dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .func_sel(func_sel),
        .a_pass(a_pass), .a_invert(a_invert), .b_pass(b_pass), .plus_one(plus_one),
        .result(result), .zero(zero), .neg(neg), .carry_out(carry_out)
    );

    // {fn[2], a_pass, a_invert, b_pass, plus_one, A[8], B[8], exp_res[8], exp_cy}
    localparam logic [30:0] VEC [17] = '{
        {2'd0, 4'b1010, 8'hCC, 8'hAA, 8'h88, 1'b0},  // R1 AND
        {2'd1, 4'b1010, 8'h12, 8'h0F, 8'hF0, 1'b0},  // R1 NOT B
        {2'd2, 4'b1010, 8'hC0, 8'h0A, 8'hCA, 1'b0},  // R1 OR
        {2'd3, 4'b1010, 8'h70, 8'h90, 8'h00, 1'b1},  // R1 R10 sum wraps to zero
        {2'd3, 4'b1011, 8'h01, 8'h02, 8'h04, 1'b0},  // R1 sum with carry-in
        {2'd3, 4'b1111, 8'h05, 8'h09, 8'h04, 1'b1},  // R6 9-5
        {2'd3, 4'b1111, 8'h09, 8'h05, 8'hFC, 1'b0},  // R6 5-9
        {2'd3, 4'b1111, 8'h3C, 8'h3C, 8'h00, 1'b1},  // R6 equal operands
        {2'd1, 4'b1100, 8'h5A, 8'h33, 8'hFF, 1'b0},  // R7
        {2'd3, 4'b0100, 8'h77, 8'h88, 8'hFF, 1'b0},  // R8 via sum
        {2'd2, 4'b0100, 8'h77, 8'h88, 8'hFF, 1'b0},  // R8 via OR
        {2'd0, 4'b0010, 8'hFF, 8'hFF, 8'h00, 1'b0},  // R2
        {2'd2, 4'b1000, 8'h3C, 8'hFF, 8'h3C, 1'b0},  // R4
        {2'd2, 4'b1011, 8'h10, 8'h01, 8'h11, 1'b0},  // R5 carry-in ignored by OR
        {2'd0, 4'b1110, 8'h0F, 8'hFF, 8'hF0, 1'b0},  // R3
        {2'd3, 4'b1011, 8'hFF, 8'h00, 8'h00, 1'b1},  // R10 carry from carry-in
        {2'd3, 4'b0110, 8'h00, 8'h80, 8'h7F, 1'b1}   // R2 R3 zeroed then inverted
    };

    task automatic check(string req, logic [7:0] er, logic ec, logic ez, logic en);
        n_run++;
        if (result !== er || carry_out !== ec || zero !== ez || neg !== en) begin
            n_fail++;
            $display("FAIL %s: got res=%h cy=%b z=%b n=%b, expected res=%h cy=%b z=%b n=%b",
                     req, result, carry_out, zero, neg, er, ec, ez, en);
        end
    endtask

    // Drive at negedge, let one posedge register it, sample 1 ns later.
    task automatic apply(logic [1:0] f, logic [3:0] c, logic [7:0] a, logic [7:0] b);
        @(negedge clk);
        func_sel = f; {a_pass, a_invert, b_pass, plus_one} = c; a_in = a; b_in = b;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", 8'h00, 1'b0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 17; i++) begin
            logic [30:0] v;
            v = VEC[i];
            apply(v[30:29], v[28:25], v[24:17], v[16:9]);
            // R9 flags follow from the expected result
            check($sformatf("R1-table entry %0d (R9 flags)", i), v[8:1], v[0],
                  v[8:1] == 8'h00, v[8]);
        end

        // R7 R5: under NOT B with B gated, A controls and carry-in do not matter
        for (int k = 0; k < 32; k++) begin
            apply(2'd1, {k[0], k[1], 1'b0, k[2]}, {k[4:3], 6'h15}, 8'hC3);
            check("R7 A controls ignored", 8'hFF, 1'b0, 1'b0, 1'b1);
        end

        // R5: carry-in ignored by AND
        apply(2'd0, 4'b1011, 8'hF0, 8'h3C);
        check("R5 AND ignores carry-in", 8'h30, 1'b0, 1'b0, 1'b0);

        // R11 latency: new inputs do not show before the next edge
        apply(2'd2, 4'b1010, 8'h81, 8'h00);
        @(negedge clk);
        func_sel = 2'd0; a_in = 8'h00;
        #1;
        check("R11 held before edge", 8'h81, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        check("R11 updated after edge", 8'h00, 1'b0, 1'b1, 1'b0);

        // R11: mid-run reset clears a carry-and-negative state
        apply(2'd3, 4'b1010, 8'hFF, 8'hFF);
        check("R10 carry with negative", 8'hFE, 1'b1, 1'b0, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 mid-run reset", 8'h00, 1'b0, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule